// File: doc/BRIEF.md
# Pseudo-Static RAM Mode and Byte-Lane Controller

This block is the control front end of a pseudo-static RAM with a 16-bit word split into two byte lanes. It turns a synchronous model of the device's asynchronous pins into an operating mode each cycle. The pins are chip select, a power-mode pin, output enable, write enable, and one enable per byte lane. The modes are standby, deep power-down, read, write, output-disabled and deselected. Reads and writes are gated lane by lane into a storage array that can be inferred as block RAM.

Two wait intervals guard the array, and both are counted in clock cycles. The power-up lockout needs a run of cycles with chip select high. The recovery interval starts after the device leaves deep power-down. While either wait is running, read and write attempts are dropped and a sticky violation flag is raised. Deep power-down also marks every stored byte as invalid. The `ready` output tells the host when accesses are accepted.

Top module: `psram_front`

## Requirements
- R1: While reset is high, and on the cycle after it falls, `ready`, `violation` and `rdata_oe` are all 0.
- R2: After reset, `ready` rises once PU_CYC consecutive clock edges have sampled `cs_n` high with `pwr_n` high. Any edge that samples `cs_n` low during this wait restarts the count.
- R3: A read is `cs_n`=0, `oe_n`=0, `we_n`=1 while ready. On the next cycle `rdata_oe[0]` equals NOT `lb_n` and `rdata_oe[1]` equals NOT `ub_n`. `rdata[7:0]` (lower lane) and `rdata[15:8]` (upper lane) carry the stored bytes, and any lane that is not driven reads 0.
- R4: A write is `cs_n`=0 and `we_n`=0 while ready, whatever the value of `oe_n`. Only the lanes whose enable is low are updated, and the other lane keeps its value.
- R5: Three pin states neither drive nor write: output-disabled (`cs_n`=0, `oe_n`=1, `we_n`=1), standby (`cs_n`=1), and both lane enables high. In all three, `rdata_oe` is 0 on the next cycle and the array is unchanged.
- R6: An edge that samples `pwr_n` low enters deep power-down. After that edge `ready` and `rdata_oe` are 0, and every stored byte is invalid.
- R7: The first edge that samples `pwr_n` high after deep power-down starts recovery. `ready` rises after REC_CYC further edges.
- R8: A read or write attempted during the power-up wait or recovery is ignored: nothing is driven and nothing is written. The attempt sets `violation`, which stays at 1 until reset.
- R9: If fewer than DPD_MIN edges sample `pwr_n` low before it returns high, `violation` is set on the exit edge.
- R10: A lane never written since reset or since the last deep power-down reads as the FILL byte (0xA5 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| pwr_n | input | 1 | Power-mode pin, low selects deep power-down |
| oe_n | input | 1 | Output enable, low active |
| we_n | input | 1 | Write enable, low active |
| ub_n | input | 1 | Upper byte lane enable, low active |
| lb_n | input | 1 | Lower byte lane enable, low active |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, undriven lanes read 0 |
| rdata_oe | output | 2 | Per-lane output drive (bit 1 upper, bit 0 lower) |
| ready | output | 1 | Accesses accepted |
| violation | output | 1 | Sticky flag for an early access or a short power-down |

## Verification
All results come from registers, so each one is due on the cycle after the edge that sampled the stimulus. This covers read data and lane drive, the new value after a write, the drop of `ready` on entering power-down, and the `violation` flag. The bench drives pins on the falling edge and samples one full clock later, on the next falling edge. The two waits are counted edge by edge from the edge that starts them. For each wait, the bench checks that `ready` is still low one edge before the bound and high exactly at it.

// File: rtl/psram_front_pkg.sv
package psram_front_pkg;
  typedef enum logic [2:0] {
    M_DEEP, M_STBY, M_DESEL, M_READ, M_WRITE, M_OUTDIS
  } pin_mode_e;

  typedef enum logic [1:0] {
    PH_PWRUP, PH_RUN, PH_DEEP, PH_RECOVER
  } phase_e;
endpackage

// File: rtl/psram_mode_dec.sv
module psram_mode_dec
  import psram_front_pkg::*;
(
  input  logic      cs_n,
  input  logic      pwr_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      ub_n,
  input  logic      lb_n,
  output pin_mode_e mode,
  output logic [1:0] lane_en
);
  assign lane_en = ~{ub_n, lb_n};

  always_comb begin
    if (!pwr_n)              mode = M_DEEP;
    else if (cs_n)           mode = M_STBY;
    else if (ub_n && lb_n)   mode = M_DESEL;
    else if (!we_n)          mode = M_WRITE;
    else if (!oe_n)          mode = M_READ;
    else                     mode = M_OUTDIS;
  end
endmodule

// File: rtl/psram_wait_ctl.sv
module psram_wait_ctl
  import psram_front_pkg::*;
#(
  parameter int PU_CYC  = 10000,
  parameter int REC_CYC = 10000,
  parameter int DPD_MIN = 500
) (
  input  logic      clk,
  input  logic      rst,
  input  pin_mode_e mode,
  input  logic      cs_n,
  output logic      ready,
  output logic      violation
);
  localparam int MAXC = (PU_CYC > REC_CYC) ? ((PU_CYC > DPD_MIN) ? PU_CYC : DPD_MIN)
                                           : ((REC_CYC > DPD_MIN) ? REC_CYC : DPD_MIN);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PU_LAST  = CW'(PU_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] DEEP_MIN = CW'(DPD_MIN);
  localparam logic [CW-1:0] ONE      = CW'(1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          viol_d;
  logic          access;

  assign access = (mode == M_READ) || (mode == M_WRITE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    viol_d  = violation;
    if (mode == M_DEEP) begin
      if (phase_q != PH_DEEP) begin
        phase_d = PH_DEEP;
        cnt_d   = ONE;
      end else if (cnt_q < DEEP_MIN) begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      case (phase_q)
        PH_PWRUP: begin
          if (cs_n) begin
            if (cnt_q == PU_LAST) begin
              phase_d = PH_RUN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            cnt_d = '0;
            if (access) viol_d = 1'b1;
          end
        end
        PH_DEEP: begin
          if (cnt_q < DEEP_MIN) viol_d = 1'b1;
          phase_d = PH_RECOVER;
          cnt_d   = '0;
        end
        PH_RECOVER: begin
          if (access) viol_d = 1'b1;
          if (cnt_q == REC_LAST) begin
            phase_d = PH_RUN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_PWRUP;
      cnt_q     <= '0;
      violation <= 1'b0;
      ready     <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      violation <= viol_d;
      ready     <= (phase_d == PH_RUN);
    end
  end
endmodule

// File: rtl/psram_lane_mem.sv
module psram_lane_mem #(
  parameter int AW    = 8,
  parameter int LANES = 2,
  parameter int LW    = 8,
  parameter logic [7:0] FILL = 8'hA5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                we,
  input  logic                re,
  input  logic [AW-1:0]       addr,
  input  logic [LANES-1:0]    be,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [LW-1:0]    q;
    logic             vq;

    always_ff @(posedge clk) begin
      if (we && be[g]) mem[addr] <= wdata[g*LW +: LW];
      if (re) q <= mem[addr];
    end

    always_ff @(posedge clk) begin
      if (rst || clr)          vld       <= '0;
      else if (we && be[g])    vld[addr] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (re) vq <= vld[addr];
    end

    assign rword[g*LW +: LW] = vq ? q : LW'(FILL);
  end
endmodule

// File: rtl/psram_front.sv
module psram_front
  import psram_front_pkg::*;
#(
  parameter int AW      = 8,
  parameter int PU_CYC  = 10000,
  parameter int REC_CYC = 10000,
  parameter int DPD_MIN = 500,
  parameter logic [7:0] FILL = 8'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          pwr_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic [1:0]    rdata_oe,
  output logic          ready,
  output logic          violation
);
  localparam int LANES = 2;
  localparam int LW    = 8;

  pin_mode_e         mode;
  logic [LANES-1:0]  lane_en;
  logic              do_wr, do_rd;
  logic [15:0]       rword;

  psram_mode_dec u_dec (
    .cs_n(cs_n), .pwr_n(pwr_n), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .mode(mode), .lane_en(lane_en)
  );

  psram_wait_ctl #(.PU_CYC(PU_CYC), .REC_CYC(REC_CYC), .DPD_MIN(DPD_MIN)) u_wait (
    .clk(clk), .rst(rst), .mode(mode), .cs_n(cs_n),
    .ready(ready), .violation(violation)
  );

  assign do_wr = ready && (mode == M_WRITE);
  assign do_rd = ready && (mode == M_READ);

  psram_lane_mem #(.AW(AW), .LANES(LANES), .LW(LW), .FILL(FILL)) u_mem (
    .clk(clk), .rst(rst), .clr(mode == M_DEEP), .we(do_wr), .re(do_rd),
    .addr(addr), .be(lane_en), .wdata(wdata), .rword(rword)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_oe <= '0;
    else     rdata_oe <= do_rd ? lane_en : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign rdata[g*LW +: LW] = rdata_oe[g] ? rword[g*LW +: LW] : '0;
  end
endmodule

// File: rtl/psram_front_chk.sv
module psram_front_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       pwr_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       ub_n,
  input logic       lb_n,
  input logic [1:0] rdata_oe,
  input logic       ready,
  input logic       violation
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!ready && !violation && rdata_oe == 2'b00));

  a_r8_sticky_violation: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

  a_r6_deep_goes_dark: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> (!ready && rdata_oe == 2'b00));

  a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
    (rdata_oe != 2'b00) |-> $past(!cs_n && !oe_n && we_n && pwr_n && ready));

  a_r5_lanes_follow_enables: assert property (@(posedge clk) disable iff (rst)
    (rdata_oe != 2'b00) |-> (rdata_oe == ~$past({ub_n, lb_n})));
endmodule

bind psram_front psram_front_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .pwr_n(pwr_n), .oe_n(oe_n), .we_n(we_n),
  .ub_n(ub_n), .lb_n(lb_n), .rdata_oe(rdata_oe), .ready(ready), .violation(violation)
);

// File: tb/tb_psram_front.sv
module tb_psram_front;
  localparam int AW   = 4;
  localparam int PU   = 20;
  localparam int REC  = 16;
  localparam int DMIN = 8;
  localparam int NV   = 15;

  localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_OD = 3'd2, OP_SB = 3'd3;

  // {op[42:40], ub_n[39], lb_n[38], addr[37:34], wdata[33:18], exp_oe[17:16], exp_data[15:0]}
  localparam logic [42:0] VEC [NV] = '{
    {OP_R,  1'b0, 1'b0, 4'd3, 16'h0000, 2'b11, 16'hA5A5}, // R10 unwritten
    {OP_W,  1'b0, 1'b0, 4'd3, 16'h1234, 2'b00, 16'h0000}, // R4
    {OP_R,  1'b0, 1'b0, 4'd3, 16'h0000, 2'b11, 16'h1234}, // R3
    {OP_W,  1'b1, 1'b0, 4'd3, 16'hFF77, 2'b00, 16'h0000}, // R4 lower only
    {OP_R,  1'b0, 1'b0, 4'd3, 16'h0000, 2'b11, 16'h1277}, // R4
    {OP_W,  1'b0, 1'b1, 4'd3, 16'h9900, 2'b00, 16'h0000}, // R4 upper only
    {OP_R,  1'b0, 1'b1, 4'd3, 16'h0000, 2'b10, 16'h9900}, // R3 upper lane
    {OP_R,  1'b1, 1'b0, 4'd3, 16'h0000, 2'b01, 16'h0077}, // R3 lower lane
    {OP_OD, 1'b0, 1'b0, 4'd3, 16'h0000, 2'b00, 16'h0000}, // R5 output disabled
    {OP_W,  1'b1, 1'b1, 4'd5, 16'h5555, 2'b00, 16'h0000}, // R5 both lanes off
    {OP_R,  1'b0, 1'b0, 4'd5, 16'h0000, 2'b11, 16'hA5A5}, // R5
    {OP_SB, 1'b0, 1'b0, 4'd5, 16'h6666, 2'b00, 16'h0000}, // R5 standby
    {OP_R,  1'b0, 1'b0, 4'd5, 16'h0000, 2'b11, 16'hA5A5}, // R5
    {OP_W,  1'b0, 1'b0, 4'd5, 16'hBEEF, 2'b00, 16'h0000}, // R4
    {OP_R,  1'b1, 1'b0, 4'd5, 16'h0000, 2'b01, 16'h00EF}  // R3
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, pwr_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic          ub_n = 1'b0, lb_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    rdata_oe;
  logic          ready, violation;
  int            checks = 0;
  int            fails = 0;

  always #10 clk = ~clk;

  psram_front #(.AW(AW), .PU_CYC(PU), .REC_CYC(REC), .DPD_MIN(DMIN), .FILL(8'hA5)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .pwr_n(pwr_n), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .ready(ready), .violation(violation)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
  endtask

  task automatic drive(input logic [2:0] op, input logic ub, input logic lb,
                       input logic [AW-1:0] a, input logic [15:0] d);
    ub_n = ub; lb_n = lb; addr = a; wdata = d;
    case (op)
      OP_W:    begin cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; end
      OP_R:    begin cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; end
      OP_OD:   begin cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; end
      default: begin cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; end
    endcase
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    check("R1 ready in reset", 32'(ready), 32'd0);
    check("R1 oe in reset", 32'(rdata_oe), 32'd0);
    rst = 1'b0;
    tick();
    check("R1 violation after reset", 32'(violation), 32'd0);

    // R2: power-up wait with a chip-select glitch that restarts it
    repeat (8) tick();
    cs_n = 1'b0;
    tick();
    cs_n = 1'b1;
    repeat (PU - 1) tick();
    check("R2 ready one edge early", 32'(ready), 32'd0);
    tick();
    check("R2 ready at bound", 32'(ready), 32'd1);
    check("R2 glitch not a violation", 32'(violation), 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][42:40], VEC[i][39], VEC[i][38], VEC[i][37:34], VEC[i][33:18]);
      tick();
      check($sformatf("R3/R4/R5/R10 vec%0d oe", i), 32'(rdata_oe), 32'(VEC[i][17:16]));
      check($sformatf("R3/R4/R5/R10 vec%0d data", i), 32'(rdata), 32'(VEC[i][15:0]));
      idle();
    end

    // R6, R7, R8: long power-down, accesses during recovery
    pwr_n = 1'b0;
    tick();
    check("R6 ready drops", 32'(ready), 32'd0);
    check("R6 no drive", 32'(rdata_oe), 32'd0);
    repeat (DMIN + 1) tick();
    pwr_n = 1'b1;
    tick();
    check("R9 long stay no violation", 32'(violation), 32'd0);
    drive(OP_W, 1'b0, 1'b0, 4'd4, 16'h1111);
    tick();
    drive(OP_R, 1'b0, 1'b0, 4'd3, 16'h0000);
    tick();
    check("R8 read in recovery not driven", 32'(rdata_oe), 32'd0);
    check("R8 violation set", 32'(violation), 32'd1);
    idle();
    repeat (REC - 3) tick();
    check("R7 ready one edge early", 32'(ready), 32'd0);
    tick();
    check("R7 ready at bound", 32'(ready), 32'd1);
    drive(OP_R, 1'b0, 1'b0, 4'd3, 16'h0000);
    tick();
    check("R6 data invalid after power-down", 32'(rdata), 32'hA5A5);
    drive(OP_R, 1'b0, 1'b0, 4'd4, 16'h0000);
    tick();
    check("R8 write in recovery ignored", 32'(rdata), 32'hA5A5);
    idle();
    tick();
    check("R8 violation sticky", 32'(violation), 32'd1);

    // R9: short power-down
    rst = 1'b1;
    tick();
    rst = 1'b0;
    repeat (PU) tick();
    check("R9 setup ready", 32'(ready), 32'd1);
    pwr_n = 1'b0;
    repeat (3) tick();
    check("R9 no violation while low", 32'(violation), 32'd0);
    pwr_n = 1'b1;
    tick();
    check("R9 short stay flagged", 32'(violation), 32'd1);

    summary();
    $finish;
  end
endmodule